// File: doc/BRIEF.md
# Transmit LED Gate with Stuck-On Guard

This block sits between a serial infrared controller's transmit data line and the LED driver of an optical transceiver. It turns the LED on only in response to a rising transmit edge, and it cuts the LED off once the input has stayed high for a fixed number of system clock cycles. This protects the emitter and the eye-safety budget when the transmit line sticks high. The LED is also held dark by the shutdown pin, by a cleared transmit-enable register bit and by the LED-disable flag raised by the serial control logic. Once any of these has cut a pulse, a fresh low-then-high transition on the transmit line is needed to light the LED again.

The block also forms the active-low receive output. In normal mode it merges the receiver's pulse with an echo of the emitted light. During shutdown it parks the output high. For the analog driver it presents the selected speed mode and the 2-bit power code. These are captured while the LED is dark, so the level never changes in the middle of a pulse. Time is counted in clock cycles: the guard window is derived from the clock frequency and a window length in nanoseconds.

Top module: `tx_led_gate`

## Requirements
- R1: After reset the LED output is low, the driver mode output is 0 (low speed) and the driver power code is 2'b11 (full power).
- R2: With shutdown low, transmit enable high and LED-disable low, a transmit line that is sampled high at a clock edge after being sampled low there turns the LED output on from that edge. The LED output goes low in the same cycle that the transmit line goes low.
- R3: The guard window length in cycles is CLK_MHZ*GUARD_NS/1000. A transmit line held high keeps the LED on for at most that many cycles, after which the LED output is low.
- R4: After a guard timeout the LED stays off while the transmit line remains high. It lights again only after the line has been sampled low and then high.
- R5: While shutdown is high, the LED output is low and the receive output is high in the same cycle, whatever the other inputs are.
- R6: While transmit enable is low or LED-disable is high, the LED output is low. If either occurs during a pulse, the pulse ends and does not resume when the condition clears with the transmit line still high.
- R7: With shutdown low, the receive output is low whenever the receiver pulse input is low or the LED output is high, and high otherwise.
- R8: The driver mode and power code outputs follow their inputs, with one cycle of delay, while no pulse is active. They hold the values captured at the pulse's starting edge for as long as the pulse lasts.
- R9: A transmit line that is already high when reset is released does not light the LED until it has gone low and risen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | 1 | Transmit data from the controller, high = light |
| shutdown | input | 1 | Shutdown pin, high = device off |
| tx_enable | input | 1 | Transmit-enable register bit |
| led_block | input | 1 | LED-disable flag from the serial control logic |
| rx_pulse_n | input | 1 | Active-low pulse from the optical receiver |
| mode_fast | input | 1 | Selected speed mode, 1 = high-speed rate |
| power_code | input | 2 | Selected optical power level, 3 = full |
| led_on | output | 1 | LED enable to the driver |
| rx_out_n | output | 1 | Active-low receive output |
| drv_fast | output | 1 | Speed mode presented to the driver |
| drv_power | output | 2 | Power code presented to the driver |

## Verification
Every cycle, the assertions check that the guard counter never passes the window, and that a pulse can start only at a detected rising edge. They also check that a closed gate clears the pulse by the next cycle, that shutdown darkens the LED and parks the receive output, that an emitted pulse pulls the receive output low, and that the driver level stays frozen through a pulse. Only the bench's scenarios can show the exact on-time for each pulse length around the window boundary. The same holds for the refusal to re-fire after a timeout or a mid-pulse disable, the behaviour of a line held high through reset, and the one-cycle delay with which the driver level follows its inputs.

// File: rtl/txg_pkg.sv
package txg_pkg;

    typedef struct packed {
        logic       fast;
        logic [1:0] power;
    } drv_level_t;

    localparam drv_level_t LEVEL_RESET = '{fast: 1'b0, power: 2'b11};

    typedef struct packed {
        logic prev;
    } edge_state_t;

    function automatic logic gate_open(input logic shdn, input logic en, input logic blk);
        return !shdn && en && !blk;
    endfunction

endpackage

// File: rtl/txg_edge.sv
module txg_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_i,
    output logic rise_o
);
    import txg_pkg::*;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = tx_i;
    end

    // previous value resets high so a line held high through reset is no edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev: 1'b1};
        else        st_q <= st_d;
    end

    assign rise_o = tx_i && !st_q.prev;

endmodule

// File: rtl/txg_guard.sv
module txg_guard #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_i,
    input  logic rise_i,
    input  logic open_i,
    output logic on_o
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

    typedef struct packed {
        logic             on;
        logic [CNT_W-1:0] cnt;
    } guard_state_t;

    guard_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!open_i || !tx_i) begin
            st_d.on  = 1'b0;
            st_d.cnt = '0;
        end else if (rise_i) begin
            st_d.on  = 1'b1;
            st_d.cnt = CNT_W'(1);
        end else if (st_q.on) begin
            if (st_q.cnt >= LIMIT_C) begin
                st_d.on  = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{on: 1'b0, cnt: '0};
        else        st_q <= st_d;
    end

    assign on_o = st_q.on;

    // R3
    cnt_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.on |-> (st_q.cnt != '0 && st_q.cnt <= LIMIT_C));

    // R4
    start_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.on) |-> $past(rise_i));

    // R6
    closed_gate_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !open_i |=> !st_q.on);

endmodule

// File: rtl/txg_rxmux.sv
module txg_rxmux (
    input  logic clk,
    input  logic rst_n,
    input  logic shdn_i,
    input  logic led_i,
    input  logic rx_pulse_n_i,
    output logic rx_n_o
);
    logic merged_n;

    always_comb begin
        merged_n = rx_pulse_n_i && !led_i;
        rx_n_o   = shdn_i ? 1'b1 : merged_n;
    end

    // R7
    echo_pulls_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shdn_i && led_i) |-> !rx_n_o);

endmodule

// File: rtl/tx_led_gate.sv
module tx_led_gate #(
    parameter int CLK_MHZ  = 200,
    parameter int GUARD_NS = 16000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_data,
    input  logic       shutdown,
    input  logic       tx_enable,
    input  logic       led_block,
    input  logic       rx_pulse_n,
    input  logic       mode_fast,
    input  logic [1:0] power_code,
    output logic       led_on,
    output logic       rx_out_n,
    output logic       drv_fast,
    output logic [1:0] drv_power
);
    import txg_pkg::*;

    localparam int TIMEOUT_CYC = (CLK_MHZ * GUARD_NS) / 1000;

    logic       rise_w;
    logic       pulse_w;
    logic       open_w;
    drv_level_t lvl_d, lvl_q;

    assign open_w = gate_open(shutdown, tx_enable, led_block);

    txg_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .tx_i   (tx_data),
        .rise_o (rise_w)
    );

    txg_guard #(.LIMIT(TIMEOUT_CYC)) u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .tx_i   (tx_data),
        .rise_i (rise_w),
        .open_i (open_w),
        .on_o   (pulse_w)
    );

    assign led_on = pulse_w && open_w && tx_data;

    txg_rxmux u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .shdn_i       (shutdown),
        .led_i        (led_on),
        .rx_pulse_n_i (rx_pulse_n),
        .rx_n_o       (rx_out_n)
    );

    // driver level is captured only while no pulse is active
    always_comb begin
        lvl_d = lvl_q;
        if (!pulse_w) begin
            lvl_d.fast  = mode_fast;
            lvl_d.power = power_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= LEVEL_RESET;
        else        lvl_q <= lvl_d;
    end

    assign drv_fast  = lvl_q.fast;
    assign drv_power = lvl_q.power;

    // R5
    shutdown_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> (!led_on && rx_out_n));

    // R8
    level_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_w && $past(pulse_w)) |-> $stable(lvl_q));

endmodule

// File: tb/tb_tx_led_gate.sv
module tb_tx_led_gate;
    localparam int MHZ = 1;
    localparam int GNS = 6000;
    localparam int WIN = (MHZ * GNS) / 1000;  // R3: 6 cycles

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_data = 1'b0, shutdown = 1'b0, tx_enable = 1'b1, led_block = 1'b0;
    logic rx_pulse_n = 1'b1, mode_fast = 1'b0;
    logic [1:0] power_code = 2'b00;
    logic led_on, rx_out_n, drv_fast;
    logic [1:0] drv_power;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tx_led_gate #(.CLK_MHZ(MHZ), .GUARD_NS(GNS)) dut (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .shutdown(shutdown),
        .tx_enable(tx_enable), .led_block(led_block), .rx_pulse_n(rx_pulse_n),
        .mode_fast(mode_fast), .power_code(power_code), .led_on(led_on),
        .rx_out_n(rx_out_n), .drv_fast(drv_fast), .drv_power(drv_power)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive high for len cycles, count sampled LED-on cycles
    task automatic pulse(input int len, output int ons);
        ons = 0;
        @(negedge clk) tx_data = 1'b1;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (led_on) ons++;
        end
        tx_data = 1'b0;
        #1;
    endtask

    initial begin
        int n;
        // R9: line high through reset release
        tx_data = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1
        check("R1 led", led_on, 0);
        check("R1 fast", drv_fast, 0);
        check("R1 power", drv_power, 3);
        n = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (led_on) n++;
        end
        check("R9 no light after reset", n, 0);
        tx_data = 1'b0;
        #1;
        check("R2 low line dark", led_on, 0);

        // R2/R3 sweep of pulse lengths across the window
        for (int len = 1; len <= WIN + 4; len++) begin
            pulse(len, n);
            check($sformatf("R3 on-cycles len=%0d", len), n, (len < WIN) ? len : WIN);
            check("R2 falls with line", led_on, 0);
            @(negedge clk);
        end

        // R4: after timeout, staying high never re-fires; then a new rise does
        pulse(3 * WIN, n);
        check("R4 single window", n, WIN);
        @(negedge clk);
        pulse(2, n);
        check("R4 relight after low", n, 2);

        // R5/R6/R7: all gate combinations with a short pulse
        for (int g = 0; g < 8; g++) begin
            int ons, rxlow;
            bit sd, en, bk, open;
            sd = g[0]; en = g[1]; bk = g[2];
            open = !sd && en && !bk;
            @(negedge clk);
            shutdown = sd; tx_enable = en; led_block = bk;
            ons = 0; rxlow = 0;
            @(negedge clk) tx_data = 1'b1;
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                if (led_on) ons++;
                if (!rx_out_n) rxlow++;
            end
            tx_data = 1'b0;
            check($sformatf("R6 gate=%0d on", g), ons, open ? 3 : 0);
            check($sformatf("R5 gate=%0d rx echo", g), rxlow, open ? 3 : 0);
            // R5 shutdown parks rx high even with receiver pulse low
            rx_pulse_n = 1'b0;
            #1;
            check($sformatf("R7 gate=%0d rx pulse", g), rx_out_n, sd ? 1 : 0);
            rx_pulse_n = 1'b1;
        end
        @(negedge clk);
        shutdown = 1'b0; tx_enable = 1'b1; led_block = 1'b0;

        // R6: mid-pulse disable does not resume
        @(negedge clk) tx_data = 1'b1;
        n = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (i == 2) led_block = 1'b1;
            if (i == 3) led_block = 1'b0;
            #1;
            if (led_on) n++;
        end
        check("R6 cut not resumed", n, 2);
        tx_data = 1'b0;
        @(negedge clk);
        tx_data = 1'b1;
        @(negedge clk) shutdown = 1'b1;
        #1;
        check("R5 immediate dark", led_on, 0);
        check("R5 rx high", rx_out_n, 1);
        tx_data = 1'b0; shutdown = 1'b0;

        // R7: receive merge with no light
        for (int v = 0; v < 2; v++) begin
            rx_pulse_n = v[0];
            #1;
            check("R7 rx follows receiver", rx_out_n, v);
        end
        rx_pulse_n = 1'b1;

        // R8: level capture and freeze
        @(negedge clk) begin power_code = 2'b01; mode_fast = 1'b1; end
        @(negedge clk);
        check("R8 power follows", drv_power, 1);
        check("R8 mode follows", drv_fast, 1);
        tx_data = 1'b1;
        @(negedge clk) begin power_code = 2'b10; mode_fast = 1'b0; end
        @(negedge clk);
        check("R8 power frozen", drv_power, 1);
        check("R8 mode frozen", drv_fast, 1);
        tx_data = 1'b0;
        @(negedge clk);
        check("R8 still held on drop edge", drv_power, 1);
        @(negedge clk);
        check("R8 power reloaded", drv_power, 2);
        check("R8 mode reloaded", drv_fast, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule